// File: doc/BRIEF.md
# Signed/Unsigned Array Multiplier

A purely combinational multiplier that takes two W-bit operands and returns their full 2W-bit product. Each partial-product row is the multiplicand gated by one multiplier bit. The row is shifted by that bit's weight and added into a running sum through a ripple chain of adder cells, one chain per row.

A mode input selects unsigned or two's-complement interpretation of both operands. The parameter `SIGN_MAG` picks how signed operands are handled on the same gate/adder array:

- When `SIGN_MAG` is 0, the rows are sign-extended to 2W bits, and the most significant row is subtracted when the multiplier is negative.
- When `SIGN_MAG` is 1, the array multiplies the operand magnitudes as unsigned values, and the sum is negated when the operand signs differ.

Top module: `mult_array`

## Requirements
- R1: With `mode_signed` = 0, `product` equals the unsigned product of `mcand` and `mplier`, all 2W bits, for every operand pair.
- R2: Unsigned, W = 4: 1011 × 1110 gives 10011010.
- R3: With `mode_signed` = 1, `product` equals the two's-complement product of the two operands (the MSB of each operand is its sign bit), written as 2W bits.
- R4: Signed, W = 4: 1011 × 0011 gives 11110001 (−15). The same bit patterns in unsigned mode give 00100001 (33).
- R5: The most negative operand 100…0 is multiplied without error in signed mode. For W = 4, 1000 × 1000 gives 01000000 (+64) and 1000 × 0111 gives 11001000 (−56).
- R6: A zero operand on either input gives a zero product in both modes.
- R7: Both settings of `SIGN_MAG` give the same product for every operand pair and mode.
- R8: A signed multiplier of all ones (−1) gives the negated multiplicand. For W = 4, 0101 × 1111 gives 11111011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| product | output | 2W | Full-width product |

## Verification
Immediate assertions inside the module run whenever the inputs change:

- They compare the array's output against an arithmetic product in each mode.
- They check that a zero operand forces a zero result.

Agreement between the two signed methods, and the specific worked bit patterns, can only be shown by the bench. The bench sweeps every operand pair in both modes through one instance of each method and compares the two instances against each other and against its own expected values.

// File: rtl/mult_array.sv
module mult_array #(
  parameter int W        = 4,
  parameter bit SIGN_MAG = 1'b0
) (
  input  logic             mode_signed,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic [2*W-1:0]   product
);
  localparam int PW = 2 * W;

  logic neg_a, neg_b, flip;
  logic [W-1:0] mc, mp;
  logic ext, sub_top;

  assign neg_a = mode_signed & mcand[W-1];
  assign neg_b = mode_signed & mplier[W-1];

  generate
    if (SIGN_MAG) begin : g_sm
      assign mc      = neg_a ? (~mcand + 1'b1) : mcand;
      assign mp      = neg_b ? (~mplier + 1'b1) : mplier;
      assign ext     = 1'b0;
      assign sub_top = 1'b0;
      assign flip    = neg_a ^ neg_b;
    end else begin : g_direct
      assign mc      = mcand;
      assign mp      = mplier;
      assign ext     = mode_signed;
      assign sub_top = neg_b;
      assign flip    = 1'b0;
    end
  endgenerate

  logic [PW-1:0] mc_wide;
  assign mc_wide = {{W{ext & mc[W-1]}}, mc};

  wire [W:0][PW-1:0]   acc;
  wire [W-1:0][PW:0]   cy;
  wire [W-1:0][PW-1:0] row;

  assign acc[0] = '0;

  genvar i, j;
  generate
    for (i = 0; i < W; i++) begin : g_row
      logic [PW-1:0] gated;
      logic          inv;
      assign gated  = ({PW{mp[i]}} & mc_wide) << i;
      assign inv    = (i == W - 1) ? sub_top : 1'b0;
      assign row[i] = inv ? ~gated : gated;
      assign cy[i][0] = inv;
      for (j = 0; j < PW; j++) begin : g_cell
        assign acc[i+1][j] = acc[i][j] ^ row[i][j] ^ cy[i][j];
        assign cy[i][j+1]  = (acc[i][j] & row[i][j]) |
                             (acc[i][j] & cy[i][j])  |
                             (row[i][j] & cy[i][j]);
      end
    end
  endgenerate

  assign product = flip ? (~acc[W] + 1'b1) : acc[W];

  logic signed [PW-1:0] sa, sb;
  logic [PW-1:0] ref_u, ref_s;
  assign sa    = PW'($signed(mcand));
  assign sb    = PW'($signed(mplier));
  assign ref_s = PW'(sa * sb);
  assign ref_u = PW'(mcand) * PW'(mplier);

  always_comb begin
    if (!mode_signed)
      assert_unsigned_product_R1: assert (product == ref_u);
    if (mode_signed)
      assert_signed_product_R3: assert (product == ref_s);
    if (mcand == '0 || mplier == '0)
      assert_zero_operand_R6: assert (product == '0);
    if (mode_signed && mplier == '1)
      assert_neg_one_R8: assert (product == PW'(-sa));
  end
endmodule

// File: tb/mult_array_tb.sv
module mult_array_tb_top;
  localparam int W = 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mode_signed;
  logic [W-1:0] mcand, mplier;
  logic [PW-1:0] p_dir, p_sm;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  mult_array #(.W(W), .SIGN_MAG(1'b0)) dut_i (
    .mode_signed(mode_signed), .mcand(mcand), .mplier(mplier), .product(p_dir));
  mult_array #(.W(W), .SIGN_MAG(1'b1)) dut_sm_i (
    .mode_signed(mode_signed), .mcand(mcand), .mplier(mplier), .product(p_sm));

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%b b=%b mode=%0d actual=%b expected=%b",
               req, mcand, mplier, mode_signed, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    mode_signed = m; mcand = a; mplier = b;
    #5;
  endtask

  function automatic logic [PW-1:0] expect_p(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
    int x, y;
    x = int'(a); y = int'(b);
    if (m && a[W-1]) x = x - (1 << W);
    if (m && b[W-1]) y = y - (1 << W);
    return PW'(x * y);
  endfunction

  initial begin
    mode_signed = 1'b0; mcand = '0; mplier = '0;
    #5;
    chk("R6 initial zero", p_dir, '0);

    apply(1'b0, 4'b1011, 4'b1110);
    chk("R2 direct", p_dir, 8'b10011010);
    chk("R2 sign-mag", p_sm, 8'b10011010);
    apply(1'b1, 4'b1011, 4'b0011);
    chk("R4 signed direct", p_dir, 8'b11110001);
    chk("R4 signed sign-mag", p_sm, 8'b11110001);
    apply(1'b0, 4'b1011, 4'b0011);
    chk("R4 unsigned view", p_dir, 8'b00100001);
    apply(1'b1, 4'b1000, 4'b1000);
    chk("R5 min*min direct", p_dir, 8'b01000000);
    chk("R5 min*min sign-mag", p_sm, 8'b01000000);
    apply(1'b1, 4'b1000, 4'b0111);
    chk("R5 min*max direct", p_dir, 8'b11001000);
    chk("R5 min*max sign-mag", p_sm, 8'b11001000);
    apply(1'b1, 4'b0101, 4'b1111);
    chk("R8 direct", p_dir, 8'b11111011);
    chk("R8 sign-mag", p_sm, 8'b11111011);

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++) begin
          apply(m[0], a[W-1:0], b[W-1:0]);
          if (m == 0) chk("R1 sweep", p_dir, expect_p(1'b0, a[W-1:0], b[W-1:0]));
          else        chk("R3 sweep", p_dir, expect_p(1'b1, a[W-1:0], b[W-1:0]));
          chk("R7 methods agree", p_sm, p_dir);
          if (a == 0 || b == 0) chk("R6 zero operand", p_dir, '0);
        end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule